// File: doc/BRIEF.md
# Cadenced Dual Tone Generator

This block produces telephony signalling tones (keypad dual-frequency digits, call progress patterns, caller-ID style alert tones) without software in the sample loop. It holds a set of independent digital oscillators, two by default. Each oscillator is a two-pole recursive sinusoid generator, gated by a hardware cadence that alternates a sounding interval with a silent interval, both counted in sample periods. Every oscillator advances once per sample strobe, which the surrounding audio datapath supplies at its sample rate (8 kHz in the intended use).

Each generator has its own coefficient (frequency), starting amplitude, sounding length, silent length and enable. A routing bit per generator sends its samples either to the receive path or to the transmit path. Generators sent to the same path are added with saturation, so two generators on one path form a dual-frequency tone with independent amplitudes. Sticky event flags record each cadence edge, and a maskable interrupt line tells the host that a flag is set.

Top module: `tone_cadence_gen`

## Requirements
- R1: After a synchronous active-low reset, `rx_sample`, `tx_sample`, `evt_flags` and `irq` are all zero.
- R2: The coefficient is signed with 14 fraction bits (value c·16384). A sounding burst starts with y = amp and y_prev = sat16((amp·coef)>>>14). Each strobe while sounding emits the current y and then sets y to sat16(((coef·y)>>>13) − y_prev) and y_prev to the old y. A generator's output changes only on the clock edge that samples `sample_stb`, and holds between strobes.
- R3: With both lengths nonzero, a generator sounds for `gen_on_len` strobes, then emits zero for `gen_off_len` strobes, and repeats. Every burst restarts from the R2 starting state.
- R4: A zero `gen_off_len` with a nonzero `gen_on_len` gives a continuous tone that never enters the silent interval and sets no event flags.
- R5: A zero `gen_on_len` keeps the generator silent, and it sets no event flags.
- R6: For generator g, flag bit 2g is set by the strobe that ends a sounding interval, and bit 2g+1 by the strobe that ends a silent interval. The flag is visible on the cycle after that strobe, and no flag is newly set in a cycle without a strobe.
- R7: Flags are sticky. A 1 in bit i of `evt_clr` clears flag i on the next edge, and a cadence event in the same cycle takes precedence.
- R8: `irq` is high exactly when some flag is set whose bit in `evt_mask` is 1.
- R9: Clearing `gen_en[g]` forces that generator's output to zero on the next edge and returns its cadence and oscillator to the start. Enabling it again begins a fresh sounding burst from amp.
- R10: `route_tx[g]` = 0 sends generator g to `rx_sample`, and 1 sends it to `tx_sample`. A path with no generator routed to it carries zero.
- R11: Each path is the sum of its routed generators, saturated to the signed range −32768..32767.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_stb | input | 1 | One-cycle pulse per audio sample period |
| gen_en | input | NGEN | Per-generator enable |
| gen_coef | input | NGEN×W | Recursion coefficient, signed, 14 fraction bits |
| gen_amp | input | NGEN×W | Starting amplitude, signed |
| gen_on_len | input | NGEN×TW | Sounding length in strobes |
| gen_off_len | input | NGEN×TW | Silent length in strobes |
| route_tx | input | NGEN | 0 = receive path, 1 = transmit path |
| evt_mask | input | 2·NGEN | Interrupt enable per flag |
| evt_clr | input | 2·NGEN | Write-one-to-clear strobe per flag |
| evt_flags | output | 2·NGEN | Sticky cadence edge flags |
| irq | output | 1 | Masked interrupt request |
| rx_sample | output | W | Receive path sample, signed |
| tx_sample | output | W | Transmit path sample, signed |

## Verification
A wrong oscillator state shows at the routed sample port on the next strobe and compounds on every strobe after it, so comparing each strobe's sample against an independent model exposes it within one sample period. A cadence counter that is off by one moves the first zero sample and the edge flag by exactly one strobe, and the flag comparison on each strobe catches it at that point. Faults in enable and routing show one cycle after the change, as a nonzero sample where zero is required.

// File: rtl/tone_cadence_pkg.sv
// Shared types and helpers for the cadenced tone generator.
// Assumes sample widths of at most 16 bits so that 32-bit arithmetic is exact.
package tone_cadence_pkg;

    typedef enum logic {
        PH_SOUND  = 1'b0,
        PH_SILENT = 1'b1
    } cad_phase_e;

    // Clamp a 32-bit signed value to the range of a w-bit signed number.
    function automatic logic signed [31:0] clamp_to(input logic signed [31:0] v,
                                                    input int unsigned w);
        logic signed [31:0] hi;
        logic signed [31:0] lo;
        hi = (32'sd1 <<< (w - 1)) - 32'sd1;
        lo = -(32'sd1 <<< (w - 1));
        if (v > hi)      return hi;
        else if (v < lo) return lo;
        else             return v;
    endfunction

endpackage

// File: rtl/tone_osc.sv
// Two-pole recursive sinusoid oscillator.
// y[n] = sat(((coef*y[n-1]) >>> (FRAC-1)) - y[n-2]); coef holds c scaled by 2^FRAC.
// load reseeds to y=amp, y_prev=amp*c (cosine start); load wins over step.
// Assumes W <= 16.
module tone_osc
    import tone_cadence_pkg::*;
#(
    parameter int W    = 16,
    parameter int FRAC = 14
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic                step,
    input  logic signed [W-1:0] coef,
    input  logic signed [W-1:0] amp,
    output logic signed [W-1:0] y
);
    logic signed [W-1:0] y_prev;
    logic signed [31:0]  mul_step;
    logic signed [31:0]  nxt_raw;
    logic signed [31:0]  nxt_sat;
    logic signed [31:0]  mul_seed;
    logic signed [31:0]  seed_sat;

    // Next recursion value and seed for the previous sample.
    always_comb begin
        mul_step = 32'(coef) * 32'(y);
        nxt_raw  = (mul_step >>> (FRAC - 1)) - 32'(y_prev);
        nxt_sat  = clamp_to(nxt_raw, W);
        mul_seed = 32'(amp) * 32'(coef);
        seed_sat = clamp_to(mul_seed >>> FRAC, W);
    end

    // Oscillator state: reseed or advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            y      <= '0;
            y_prev <= '0;
        end else if (load) begin
            y      <= amp;
            y_prev <= seed_sat[W-1:0];
        end else if (step) begin
            y      <= nxt_sat[W-1:0];
            y_prev <= y;
        end
    end

endmodule

// File: rtl/tone_cadence.sv
// Sounding/silent cadence sequencer for one generator, counted in sample strobes.
// Zero on_len: never sounds, no events. Zero off_len: continuous, no events.
// Disabling returns to the start of a sounding interval.
module tone_cadence
    import tone_cadence_pkg::*;
#(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          stb,
    input  logic [TW-1:0] on_len,
    input  logic [TW-1:0] off_len,
    output logic          sounding,
    output logic          osc_load,
    output logic          osc_step,
    output logic          off_evt,
    output logic          on_evt
);
    cad_phase_e    phase;
    logic [TW-1:0] cnt;
    logic [TW:0]   cnt_nx;
    logic          run;

    // Interval end detection and oscillator control.
    always_comb begin
        run      = en && stb && (on_len != '0);
        cnt_nx   = {1'b0, cnt} + 1'b1;
        off_evt  = run && (phase == PH_SOUND) && (off_len != '0) && (cnt_nx >= {1'b0, on_len});
        on_evt   = run && (phase == PH_SILENT) && (cnt_nx >= {1'b0, off_len});
        sounding = (phase == PH_SOUND) && (on_len != '0);
        osc_load = !en || off_evt;
        osc_step = run && (phase == PH_SOUND) && !off_evt;
    end

    // Phase and interval counter.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            phase <= PH_SOUND;
            cnt   <= '0;
        end else if (run) begin
            if (off_evt) begin
                phase <= PH_SILENT;
                cnt   <= '0;
            end else if (on_evt) begin
                phase <= PH_SOUND;
                cnt   <= '0;
            end else if (phase == PH_SOUND && off_len == '0) begin
                cnt   <= '0;
            end else begin
                cnt   <= cnt_nx[TW-1:0];
            end
        end
    end

endmodule

// File: rtl/tone_mix.sv
// Routes each generator to the receive or transmit path and sums each path
// with saturation to W bits. Assumes W <= 16 and a small NGEN.
module tone_mix
    import tone_cadence_pkg::*;
#(
    parameter int NGEN = 2,
    parameter int W    = 16
) (
    input  logic [NGEN-1:0][W-1:0] smp,
    input  logic [NGEN-1:0]        route_tx,
    output logic signed [W-1:0]    rx_o,
    output logic signed [W-1:0]    tx_o
);
    logic signed [31:0] acc_rx;
    logic signed [31:0] acc_tx;
    logic signed [31:0] sat_rx;
    logic signed [31:0] sat_tx;

    // Per-path accumulation and clamp.
    always_comb begin
        acc_rx = '0;
        acc_tx = '0;
        for (int g = 0; g < NGEN; g++) begin
            if (route_tx[g]) acc_tx = acc_tx + 32'(signed'(smp[g]));
            else             acc_rx = acc_rx + 32'(signed'(smp[g]));
        end
        sat_rx = clamp_to(acc_rx, W);
        sat_tx = clamp_to(acc_tx, W);
        rx_o   = sat_rx[W-1:0];
        tx_o   = sat_tx[W-1:0];
    end

endmodule

// File: rtl/tone_cadence_gen.sv
// Cadenced multi-generator tone source. Each generator is an oscillator gated
// by a sounding/silent cadence; cadence edges set sticky flags behind a mask.
// Assumes sample_stb is a single-cycle pulse and W <= 16.
module tone_cadence_gen
    import tone_cadence_pkg::*;
#(
    parameter int NGEN = 2,
    parameter int W    = 16,
    parameter int TW   = 16,
    parameter int FRAC = 14
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   sample_stb,
    input  logic [NGEN-1:0]        gen_en,
    input  logic [NGEN-1:0][W-1:0] gen_coef,
    input  logic [NGEN-1:0][W-1:0] gen_amp,
    input  logic [NGEN-1:0][TW-1:0] gen_on_len,
    input  logic [NGEN-1:0][TW-1:0] gen_off_len,
    input  logic [NGEN-1:0]        route_tx,
    input  logic [2*NGEN-1:0]      evt_mask,
    input  logic [2*NGEN-1:0]      evt_clr,
    output logic [2*NGEN-1:0]      evt_flags,
    output logic                   irq,
    output logic signed [W-1:0]    rx_sample,
    output logic signed [W-1:0]    tx_sample
);
    localparam int NFLAG = 2 * NGEN;

    logic [NGEN-1:0][W-1:0] smp;
    logic [NFLAG-1:0]       evt_set;

    for (genvar g = 0; g < NGEN; g++) begin : g_gen
        logic                sounding;
        logic                osc_load;
        logic                osc_step;
        logic signed [W-1:0] osc_y;

        tone_cadence #(.TW(TW)) u_cad (
            .clk      (clk),
            .rst_n    (rst_n),
            .en       (gen_en[g]),
            .stb      (sample_stb),
            .on_len   (gen_on_len[g]),
            .off_len  (gen_off_len[g]),
            .sounding (sounding),
            .osc_load (osc_load),
            .osc_step (osc_step),
            .off_evt  (evt_set[2*g]),
            .on_evt   (evt_set[2*g+1])
        );

        tone_osc #(.W(W), .FRAC(FRAC)) u_osc (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (osc_load),
            .step  (osc_step),
            .coef  (signed'(gen_coef[g])),
            .amp   (signed'(gen_amp[g])),
            .y     (osc_y)
        );

        // Per-generator sample register, updated once per strobe.
        always_ff @(posedge clk) begin
            if (!rst_n || !gen_en[g]) smp[g] <= '0;
            else if (sample_stb)      smp[g] <= sounding ? osc_y : '0;
        end
    end

    // Sticky event flags: events override clears.
    always_ff @(posedge clk) begin
        if (!rst_n) evt_flags <= '0;
        else        evt_flags <= (evt_flags & ~evt_clr) | evt_set;
    end

    assign irq = |(evt_flags & evt_mask);

    tone_mix #(.NGEN(NGEN), .W(W)) u_mix (
        .smp      (smp),
        .route_tx (route_tx),
        .rx_o     (rx_sample),
        .tx_o     (tx_sample)
    );

endmodule

// File: rtl/tone_cadence_gen_chk.sv
// Port-level temporal checks for tone_cadence_gen, attached by bind.
module tone_cadence_gen_chk #(
    parameter int NGEN = 2,
    parameter int W    = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                sample_stb,
    input logic [NGEN-1:0]     gen_en,
    input logic [NGEN-1:0]     route_tx,
    input logic [2*NGEN-1:0]   evt_clr,
    input logic [2*NGEN-1:0]   evt_flags,
    input logic signed [W-1:0] rx_sample,
    input logic signed [W-1:0] tx_sample
);
    // R2: outputs hold without a strobe, unless routing moved.
    p_hold_between_strobes_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!sample_stb && $stable(gen_en)) |=>
        (($stable(rx_sample) && $stable(tx_sample)) || !$stable(route_tx)));

    // R6: no flag rises in a cycle without a strobe.
    p_flag_needs_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_stb |=> ((evt_flags & ~$past(evt_flags)) == '0));

    // R7: flags never drop unless cleared.
    p_flags_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(evt_flags) & ~$past(evt_clr) & ~evt_flags) == '0));

    // R7: a clear with no strobe takes effect on the next edge.
    p_clear_applies_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_stb |=> ((evt_flags & $past(evt_clr)) == '0));

    // R9: all generators disabled gives silence on both paths.
    p_disabled_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_en == '0) |=> (rx_sample == '0 && tx_sample == '0));

endmodule

bind tone_cadence_gen tone_cadence_gen_chk #(.NGEN(NGEN), .W(W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sample_stb (sample_stb),
    .gen_en     (gen_en),
    .route_tx   (route_tx),
    .evt_clr    (evt_clr),
    .evt_flags  (evt_flags),
    .rx_sample  (rx_sample),
    .tx_sample  (tx_sample)
);

// File: tb/test_tone_cadence_gen.sv
module test_tone_cadence_gen;
    localparam int NGEN = 2;
    localparam int W    = 16;
    localparam int TW   = 16;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    stb = 1'b0;
    logic [NGEN-1:0]         en = '0;
    logic [NGEN-1:0][W-1:0]  coef = '0;
    logic [NGEN-1:0][W-1:0]  amp = '0;
    logic [NGEN-1:0][TW-1:0] on_len = '0;
    logic [NGEN-1:0][TW-1:0] off_len = '0;
    logic [NGEN-1:0]         route = '0;
    logic [2*NGEN-1:0]       mask = '0;
    logic [2*NGEN-1:0]       clr = '0;
    logic [2*NGEN-1:0]       flags;
    logic                    irq;
    logic signed [W-1:0]     rx;
    logic signed [W-1:0]     tx;

    always #10 clk = ~clk;

    tone_cadence_gen #(.NGEN(NGEN), .W(W), .TW(TW)) i_tone_cadence_gen (
        .clk(clk), .rst_n(rst_n), .sample_stb(stb), .gen_en(en),
        .gen_coef(coef), .gen_amp(amp), .gen_on_len(on_len), .gen_off_len(off_len),
        .route_tx(route), .evt_mask(mask), .evt_clr(clr), .evt_flags(flags),
        .irq(irq), .rx_sample(rx), .tx_sample(tx)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        int               rx;
        int               tx;
        logic [2*NGEN-1:0] fl;
        string            tag;
    } exp_t;
    exp_t q[$];

    // Reference model state
    int   m_y[NGEN], m_yp[NGEN], m_cnt[NGEN], m_smp[NGEN];
    bit   m_off[NGEN];
    logic [2*NGEN-1:0] m_flags = '0;

    function automatic int sat16(int v);
        if (v > 32767)  return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic m_seed(int g);
        int a, c;
        a = $signed(amp[g]);
        c = $signed(coef[g]);
        m_y[g]  = a;
        m_yp[g] = sat16((a * c) >>> 14);
    endtask

    task automatic m_reset(int g);
        m_off[g] = 0;
        m_cnt[g] = 0;
        m_smp[g] = 0;
        m_seed(g);
    endtask

    task automatic m_step(int g);
        int onl, offl, c, nxt;
        onl = int'(on_len[g]);
        offl = int'(off_len[g]);
        c = $signed(coef[g]);
        if (!en[g] || onl == 0) begin
            m_smp[g] = 0;
        end else if (!m_off[g]) begin
            m_smp[g] = m_y[g];
            if (offl != 0 && m_cnt[g] + 1 >= onl) begin
                m_off[g] = 1;
                m_cnt[g] = 0;
                m_flags[2*g] = 1'b1;
                m_seed(g);
            end else begin
                m_cnt[g] = (offl == 0) ? 0 : m_cnt[g] + 1;
                nxt = sat16(((c * m_y[g]) >>> 13) - m_yp[g]);
                m_yp[g] = m_y[g];
                m_y[g] = nxt;
            end
        end else begin
            m_smp[g] = 0;
            if (m_cnt[g] + 1 >= offl) begin
                m_off[g] = 0;
                m_cnt[g] = 0;
                m_flags[2*g+1] = 1'b1;
            end else begin
                m_cnt[g]++;
            end
        end
    endtask

    // Driver: advance model, push expectation, issue one strobe.
    task automatic pulse(string tag);
        exp_t e;
        int sr, st;
        sr = 0; st = 0;
        for (int g = 0; g < NGEN; g++) begin
            m_step(g);
            if (route[g]) st += m_smp[g];
            else          sr += m_smp[g];
        end
        e.rx = sat16(sr);
        e.tx = sat16(st);
        e.fl = m_flags;
        e.tag = tag;
        q.push_back(e);
        @(negedge clk) stb = 1'b1;
        @(negedge clk) stb = 1'b0;
        @(negedge clk);
    endtask

    task automatic clear_flags(logic [2*NGEN-1:0] v);
        @(negedge clk) clr = v;
        @(negedge clk) clr = '0;
        m_flags = m_flags & ~v;
    endtask

    // Monitor: compare each strobe's result one edge later.
    initial begin
        forever begin
            @(posedge clk);
            if (stb) begin
                @(negedge clk);
                if (q.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R2 unexpected strobe actual=1 expected=0");
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk({e.tag, " rx"}, int'(rx), e.rx);
                    chk({e.tag, " tx"}, int'(tx), e.tx);
                    chk({e.tag, " flags"}, int'(flags), int'(e.fl));
                end
            end
        end
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 rx", int'(rx), 0);
        chk("R1 tx", int'(tx), 0);
        chk("R1 flags", int'(flags), 0);
        chk("R1 irq", int'(irq), 0);

        // R2/R3: generator 0, 1 kHz-like, 5 on / 3 off, receive path
        coef[0] = 16'd11585; amp[0] = 16'd8000; on_len[0] = 16'd5; off_len[0] = 16'd3;
        route[0] = 1'b0;
        m_reset(0); m_reset(1);
        @(negedge clk) en[0] = 1'b1;
        pulse("R2 first");
        chk("R2 first sample", int'(rx), 8000);
        repeat (3) @(negedge clk);
        chk("R2 hold", int'(rx), 8000);
        for (int i = 0; i < 19; i++) pulse("R3 cadence");
        chk("R6 off flag", int'(flags[0]), 1);
        chk("R6 on flag", int'(flags[1]), 1);

        // R8: mask behaviour
        chk("R8 masked", int'(irq), 0);
        @(negedge clk) mask = 4'b0001;
        @(negedge clk) chk("R8 unmasked", int'(irq), 1);
        // R7: clear bit 0
        clear_flags(4'b0001);
        @(negedge clk);
        chk("R7 cleared", int'(flags), int'(m_flags));
        chk("R8 after clear", int'(irq), 0);
        @(negedge clk) mask = '0;

        // R9: disable mid-stream, then restart
        @(negedge clk) en[0] = 1'b0;
        @(negedge clk) chk("R9 disabled", int'(rx), 0);
        m_reset(0);
        @(negedge clk) en[0] = 1'b1;
        pulse("R9 restart");
        chk("R9 restart amp", int'(rx), 8000);
        @(negedge clk) en[0] = 1'b0;
        m_reset(0);
        clear_flags('1);

        // R4/R10: generator 1 continuous on transmit path
        coef[1] = 16'd15137; amp[1] = 16'd5000; on_len[1] = 16'd4; off_len[1] = 16'd0;
        route[1] = 1'b1;
        m_reset(1);
        @(negedge clk) en[1] = 1'b1;
        for (int i = 0; i < 15; i++) pulse("R4 continuous");
        chk("R4 no flags", int'(flags), 0);
        chk("R10 rx idle", int'(rx), 0);
        @(negedge clk) en[1] = 1'b0;
        m_reset(1);

        // R5: zero sounding length stays silent
        on_len[0] = 16'd0; off_len[0] = 16'd2;
        m_reset(0);
        @(negedge clk) en[0] = 1'b1;
        for (int i = 0; i < 6; i++) pulse("R5 silent");
        chk("R5 no flags", int'(flags), 0);
        @(negedge clk) en[0] = 1'b0;

        // R11: both on receive path, saturating sum
        coef[0] = 16'd16000; amp[0] = 16'd30000; on_len[0] = 16'd6; off_len[0] = 16'd2;
        coef[1] = 16'd12000; amp[1] = 16'd30000; on_len[1] = 16'd3; off_len[1] = 16'd4;
        route = 2'b00;
        m_reset(0); m_reset(1);
        @(negedge clk) en = 2'b11;
        pulse("R11 sum");
        chk("R11 positive clamp", int'(rx), 32767);
        for (int i = 0; i < 10; i++) pulse("R11 sum");

        // R10: split routing
        @(negedge clk) route = 2'b10;
        for (int i = 0; i < 8; i++) pulse("R10 split");

        repeat (4) @(negedge clk);
        chk("R2 queue drained", q.size(), 0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule